// File: doc/BRIEF.md
# Sprite Attribute Table Port

This block is the processor-side access port into a 544-byte sprite attribute store. The store has a 512-byte main area and a 32-byte upper area. The block holds the store itself. It keeps a 9-bit base address, a 10-bit byte pointer, a one-byte pairing latch, a rotation-enable flag, the last byte read, and a 7-bit first-sprite index that the sprite renderer uses to rotate sprite priority.

Software programs the base through two address-byte writes and then streams data writes or reads through one data port. Writes to the main area are committed two bytes at a time. The upper area is written one byte at a time and repeats every 32 bytes. While the picture is being drawn, the scan hardware owns the store. Every data access then uses the scan address input in place of the pointer.

Top module: `sprite_attr_port`

## Requirements
- R1: A write with `wr_sel`=0 loads base bits 7..0 from the data. A write with `wr_sel`=1 loads base bit 8 from data bit 0 and the rotation enable from data bit 7. Either write reloads the pointer with twice the base, so the pointer equals {base, 0}.
- R2: Every data write (`wr_sel`=2) and every data read advances the pointer by one, modulo 1024. Pointer 1023 wraps to 0.
- R3: A data write with pointer bit 9 clear and pointer bit 0 clear changes no stored byte. It only captures the data in the pairing latch.
- R4: A data write with pointer bit 9 clear and pointer bit 0 set stores the latch into the even byte and the data into the odd byte of that pair.
- R5: A data write with pointer bit 9 set stores its byte at once. An address with bit 9 set selects upper-area byte number (address & 31), so the upper area repeats every 32 bytes.
- R6: After each data access, `first_idx` equals bits 8..2 of the advanced pointer when rotation is enabled, and 0 when it is disabled.
- R7: While `disp_on` is high and `line` is below 225 (below 240 when `tall_mode` is high), data reads and data writes use `scan_addr` in place of the pointer. In that window a pair commit stores only the data byte, at the folded scan address. The pointer still advances.
- R8: A data read returns the byte at the effective address on `rd_data` one cycle later. `rd_data` holds that value until the next data read.
- R9: After reset, `rd_data` is 0xFF, `first_idx` is 0, the base and pointer are 0, and rotation is disabled.
- R10: When `wr_en` and `rd_en` are high in the same cycle, the write is performed and the read is ignored. `rd_data` stays unchanged and the pointer does not take the read's step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 base low, 1 base high, 2 data, 3 none |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Data read strobe |
| disp_on | input | 1 | Display enabled |
| tall_mode | input | 1 | Extended 240-line picture |
| line | input | LINE_W | Current scan line |
| scan_addr | input | 10 | Address from the scan hardware |
| rd_data | output | 8 | Last byte read |
| first_idx | output | 7 | First sprite for priority rotation |

## Verification
The bench first fills the whole store, including the upper area, through the pointer. It then goes after the pairing rule. A design that committed even bytes at once would let a read after an even-only write return the new byte instead of the old one. Mirroring is probed by writing the upper area and reading it back at the aliased addresses, and by wrapping the pointer from 1023 to 0. A design without folding would return unrelated bytes or index past the store. The bench also places the line counter on both sides of 225 and 240 with redirection on, and toggles rotation to check `first_idx`. It mixes these directed cases with random accesses checked against a bench model.

// File: rtl/sprite_attr_port.sv
module sprite_attr_port #(
  parameter int LINE_W        = 9,
  parameter int VIS_LINES     = 225,
  parameter int VIS_LINES_TALL = 240,
  parameter int MAIN_BYTES    = 512,
  parameter int HIGH_BYTES    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic              disp_on,
  input  logic              tall_mode,
  input  logic [LINE_W-1:0] line,
  input  logic [9:0]        scan_addr,
  output logic [7:0]        rd_data,
  output logic [6:0]        first_idx
);
  localparam int DEPTH  = MAIN_BYTES + HIGH_BYTES;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int HIGH_W = $clog2(HIGH_BYTES);
  localparam logic [1:0] SEL_LO = 2'd0, SEL_HI = 2'd1, SEL_DATA = 2'd2;

  logic [7:0] store [DEPTH];
  logic [8:0] base_q;
  logic [9:0] ptr_q;
  logic [7:0] latch_q;
  logic       rot_q;
  logic [7:0] rd_q;
  logic [6:0] first_q;

  function automatic logic [IDX_W-1:0] fold(input logic [9:0] a);
    if (a[9]) fold = IDX_W'(MAIN_BYTES) + IDX_W'(a[HIGH_W-1:0]);
    else      fold = IDX_W'(a[8:0]);
  endfunction

  wire [LINE_W-1:0] vis_end = tall_mode ? LINE_W'(VIS_LINES_TALL) : LINE_W'(VIS_LINES);
  wire        busy    = disp_on && (line < vis_end);
  wire [9:0]  eff     = busy ? scan_addr : ptr_q;
  wire        do_wr   = wr_en && (wr_sel == SEL_DATA);
  wire        do_rd   = rd_en && !wr_en;
  wire        access  = do_wr || do_rd;
  wire [9:0]  ptr_nx  = ptr_q + 10'd1;

  wire        put_one  = do_wr && (ptr_q[9] || (ptr_q[0] && busy));
  wire        put_pair = do_wr && !ptr_q[9] && ptr_q[0] && !busy;
  wire        hold_lat = do_wr && !ptr_q[9] && !ptr_q[0];

  wire [8:0]  base_lo = {base_q[8], wr_data};
  wire [8:0]  base_hi = {wr_data[0], base_q[7:0]};

  always_ff @(posedge clk) begin
    if (put_one) store[fold(eff)] <= wr_data;
    if (put_pair) begin
      store[fold({ptr_q[9:1], 1'b0})] <= latch_q;
      store[fold({ptr_q[9:1], 1'b1})] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      ptr_q   <= '0;
      latch_q <= '0;
      rot_q   <= 1'b0;
      rd_q    <= 8'hFF;
      first_q <= '0;
    end else begin
      if (wr_en && wr_sel == SEL_LO) begin
        base_q <= base_lo;
        ptr_q  <= {base_lo, 1'b0};
      end else if (wr_en && wr_sel == SEL_HI) begin
        base_q <= base_hi;
        rot_q  <= wr_data[7];
        ptr_q  <= {base_hi, 1'b0};
      end else if (access) begin
        ptr_q   <= ptr_nx;
        first_q <= rot_q ? ptr_nx[8:2] : 7'd0;
      end
      if (hold_lat) latch_q <= wr_data;
      if (do_rd)    rd_q    <= store[fold(eff)];
    end
  end

  assign rd_data   = rd_q;
  assign first_idx = first_q;

  assert_ptr_reload_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_LO) |=> (ptr_q == {base_q, 1'b0}));
  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> (ptr_q == $past(ptr_q) + 10'd1));
  assert_rot_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (access && rot_q) |=> (first_idx == ptr_q[8:2]));
  assert_rot_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !rot_q) |=> (first_idx == 7'd0));
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !do_rd |=> $stable(rd_data));
  assert_rd_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> $stable(rd_data));
endmodule

// File: tb/sprite_attr_port_tb.sv
module sprite_attr_port_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n, wr_en, rd_en, disp_on, tall_mode;
  logic [1:0] wr_sel;
  logic [7:0] wr_data, rd_data;
  logic [8:0] line;
  logic [9:0] scan_addr;
  logic [6:0] first_idx;

  sprite_attr_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .disp_on(disp_on), .tall_mode(tall_mode), .line(line),
    .scan_addr(scan_addr), .rd_data(rd_data), .first_idx(first_idx));

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_mem [544];
  logic [8:0] m_base;
  logic [9:0] m_ptr;
  logic [7:0] m_latch, m_rd;
  logic       m_rot;
  logic [6:0] m_first;

  function automatic int fidx(input logic [9:0] a);
    return a[9] ? 512 + int'(a[4:0]) : int'(a[8:0]);
  endfunction

  function automatic bit m_busy();
    return disp_on && (int'(line) < (tall_mode ? 240 : 225));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic env(input bit d, input bit t, input int l, input int s);
    disp_on = d; tall_mode = t; line = 9'(l); scan_addr = 10'(s);
  endtask

  task automatic advance();
    m_ptr   = m_ptr + 10'd1;
    m_first = m_rot ? m_ptr[8:2] : 7'd0;
  endtask

  task automatic op_addr(input bit hi, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = hi ? 2'd1 : 2'd0; wr_data = d;
    if (hi) begin m_base[8] = d[0]; m_rot = d[7]; end
    else m_base[7:0] = d;
    m_ptr = {m_base, 1'b0};
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic op_wr(input logic [7:0] d, input string tag);
    logic [9:0] e;
    e = m_busy() ? scan_addr : m_ptr;
    @(negedge clk);
    wr_en = 1; wr_sel = 2'd2; wr_data = d;
    if (m_ptr[9]) m_mem[fidx(e)] = d;
    else if (!m_ptr[0]) m_latch = d;
    else if (m_busy()) m_mem[fidx(e)] = d;
    else begin
      m_mem[fidx({m_ptr[9:1], 1'b0})] = m_latch;
      m_mem[fidx({m_ptr[9:1], 1'b1})] = d;
    end
    advance();
    @(negedge clk);
    wr_en = 0;
    chk({tag, " first_idx"}, first_idx, m_first);
  endtask

  task automatic op_rd(input string tag);
    logic [9:0] e;
    e = m_busy() ? scan_addr : m_ptr;
    @(negedge clk);
    rd_en = 1;
    m_rd = m_mem[fidx(e)];
    advance();
    @(negedge clk);
    rd_en = 0;
    chk({tag, " rd_data"}, rd_data, m_rd);
    chk({tag, " first_idx"}, first_idx, m_first);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 0; wr_en = 0; rd_en = 0; wr_sel = 0; wr_data = 0;
    env(0, 0, 0, 0);
    m_base = 0; m_ptr = 0; m_latch = 0; m_rot = 0; m_first = 0; m_rd = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 rd_data", rd_data, 8'hFF);
    chk("R9 first_idx", first_idx, 0);

    // fill the whole store through the pointer (R2, R4, R5)
    for (int i = 0; i < 544; i++) op_wr(8'(i * 7 + 3), "fill");
    op_addr(0, 8'h00); op_addr(1, 8'h00);
    op_rd("R4 fill pair byte0");
    op_rd("R4 fill pair byte1");

    // R3 even write alone does not commit
    op_addr(0, 8'h10);
    op_wr(8'hA1, "R3 even");
    op_addr(0, 8'h10);
    op_rd("R3 even untouched");
    // R4 pair commit
    op_addr(0, 8'h10);
    op_wr(8'hB2, "R4 even");
    op_wr(8'hC3, "R4 odd");
    op_addr(0, 8'h10);
    op_rd("R4 pair even");
    op_rd("R4 pair odd");
    chk("R4 odd value", rd_data, 8'hC3);

    // R5 upper area direct write and 32-byte mirroring
    op_addr(1, 8'h01); op_addr(0, 8'h05);
    op_wr(8'h5A, "R5 direct");
    op_addr(0, 8'h15);
    op_rd("R5 mirror");
    chk("R5 mirror value", rd_data, 8'h5A);

    // R2 wrap 1023 -> 0, R6 rotation on
    op_addr(1, 8'h81); op_addr(0, 8'hFF);
    op_rd("R2 ptr 1022");
    op_rd("R2 ptr 1023");
    op_rd("R2 wrap to 0");
    chk("R6 index after wrap", first_idx, 0);
    op_rd("R6 rotation step");
    op_rd("R6 rotation step2");
    op_rd("R6 rotation step3");
    chk("R6 index ptr4", first_idx, 1);
    op_addr(1, 8'h00);
    op_rd("R6 rotation off");

    // R7 redirection boundaries
    env(1, 0, 224, 10'h030);
    op_rd("R7 line 224 redirected");
    env(1, 0, 225, 10'h030);
    op_rd("R7 line 225 pointer");
    env(1, 1, 239, 10'h208);
    op_addr(0, 8'h20);
    op_wr(8'h11, "R7 even latch");
    op_wr(8'h77, "R7 busy pair");
    env(0, 1, 239, 10'h208);
    op_addr(1, 8'h01); op_addr(0, 8'h04);
    op_rd("R7 busy write landed");
    chk("R7 landed value", rd_data, 8'h77);
    env(1, 1, 240, 0);
    op_rd("R7 line 240 tall pointer");

    // R10 write wins over read
    env(0, 0, 0, 0);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'd0; wr_data = 8'h33; rd_en = 1;
    m_base[7:0] = 8'h33; m_ptr = {m_base, 1'b0};
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    chk("R10 rd_data held", rd_data, m_rd);
    op_rd("R10 pointer from reload");

    // random mix
    for (int k = 0; k < 600; k++) begin
      int op;
      env($urandom % 2, $urandom % 2, $urandom % 262, $urandom % 1024);
      op = $urandom % 8;
      if (op == 0) op_addr(0, 8'($urandom));
      else if (op == 1) op_addr(1, 8'($urandom));
      else if (op < 5) op_wr(8'($urandom), "R4/R5/R7 random write");
      else op_rd("R8 random read");
    end
    finish_run();
  end
endmodule